// File: doc/BRIEF.md
# Dual-Mode Unsigned Long Divider

This execution unit performs the unsigned long-divide operation of a 32-bit processor. A single `start` pulse hands it a 32-bit divisor, the current contents of two data registers (a quotient register and a remainder register) and their 3-bit indices. A mode bit selects the dividend. In narrow mode the dividend is the quotient register alone. In wide mode the dividend is 64 bits, made from the remainder register (upper half) and the quotient register (lower half).

The unit latches its operands and then spends one setup cycle screening for a zero divisor or a quotient that cannot fit in 32 bits. If neither applies, it runs a restoring shift-subtract loop that produces one quotient bit per cycle. It ends every operation with a one-cycle `done` pulse. In that cycle it presents two write-back requests, one for the quotient and one for the remainder, together with the N, Z, V and C condition flags. The surrounding pipeline commits these into the register file and the status register.

Top module: `udiv_long`

## Requirements
- R1: With `size64`=0 the dividend is `qreg_val` alone, and `rreg_val` has no effect on any result. The quotient is requested for index `qreg_idx` and the remainder for index `rreg_idx`.
- R2: With `size64`=1 the dividend is the 64-bit value {`rreg_val`,`qreg_val`}. The 32-bit quotient and the 32-bit remainder are delivered on `q_wdata` and `r_wdata`.
- R3: When `qreg_idx` equals `rreg_idx` and the division succeeds, `q_we`=1 and `r_we`=0, so the remainder is discarded. `r_we` is never high without `q_we`.
- R4: On success, Z=1 exactly when the quotient is zero, N equals quotient bit 31, V=0 and C=0.
- R5: A zero divisor raises `div_zero` only in the `done` cycle. It requests no register write and leaves N, Z, V and C all 0.
- R6: In wide mode, when `rreg_val` >= a non-zero divisor, V=1 in the `done` cycle. No write is requested, and N, Z and C are 0.
- R7: On success, `done` is first seen high after 34 rising edges, counting the edge that samples `start`. For a zero divisor or an overflow it is seen after 2 edges. `done` lasts exactly one cycle.
- R8: A `start` that arrives while `busy` is high is ignored. It neither alters the running result nor causes a second `done`.
- R9: After reset `busy`, `done`, `q_we`, `r_we`, `div_zero` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division (sampled only when idle) |
| size64 | input | 1 | 0: 32-bit dividend, 1: 64-bit dividend |
| divisor | input | 32 | Unsigned divisor |
| qreg_val | input | 32 | Quotient register contents (low dividend half) |
| rreg_val | input | 32 | Remainder register contents (high half in wide mode) |
| qreg_idx | input | 3 | Quotient register index |
| rreg_idx | input | 3 | Remainder register index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Divisor was zero (with done) |
| q_we | output | 1 | Quotient write request |
| q_widx | output | 3 | Quotient write index |
| q_wdata | output | 32 | Quotient value |
| r_we | output | 1 | Remainder write request |
| r_widx | output | 3 | Remainder write index |
| r_wdata | output | 32 | Remainder value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag (always 0) |

## Verification
Narrow-mode runs use a small dividend over a large divisor, a zero dividend, and an all-ones dividend over 1. Together they separate the remainder path from the quotient path and exercise Z and N. Each narrow case is repeated with different remainder-register contents, which exposes any leak of the upper half into narrow mode. Wide-mode runs use an upper half one below the divisor, equal to it, and above it, which pins the overflow boundary exactly. Equal indices, a zero divisor and a `start` injected mid-operation check the write-suppression rules and the busy lockout.

// File: rtl/ldiv_pkg.sv
package ldiv_pkg;

    localparam int unsigned LDIV_DATA_W = 32;
    localparam int unsigned LDIV_IDX_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ITER  = 2'd2,
        ST_FIN   = 2'd3
    } ldiv_state_e;

    typedef enum logic [1:0] {
        OUT_OK  = 2'd0,
        OUT_DZ  = 2'd1,
        OUT_OVF = 2'd2
    } ldiv_outcome_e;

    // Classify an operation at setup time from divisor and upper dividend half.
    function automatic ldiv_outcome_e ldiv_classify(input logic dvsr_zero, input logic hi_ge);
        if (dvsr_zero)  return OUT_DZ;
        else if (hi_ge) return OUT_OVF;
        else            return OUT_OK;
    endfunction

endpackage

// File: rtl/ldiv_ctrl.sv
module ldiv_ctrl
    import ldiv_pkg::*;
#(
    parameter int unsigned ITERS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        setup_fail,
    output ldiv_state_e state,
    output logic        load,
    output logic        step_en,
    output logic        busy,
    output logic        done
);
    localparam int unsigned CW = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

    ldiv_state_e   state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start) state_q <= ST_SETUP;
                ST_SETUP: begin
                    cnt_q   <= '0;
                    state_q <= setup_fail ? ST_FIN : ST_ITER;
                end
                ST_ITER: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= ST_FIN;
                end
                ST_FIN:   state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign state   = state_q;
    assign load    = start && (state_q == ST_IDLE);
    assign step_en = (state_q == ST_ITER);
    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_FIN);

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (state_q != ST_SETUP)); // R8
    AST_ITER_RUNS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ITER && cnt_q != LAST) |=> (state_q == ST_ITER)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
endmodule

// File: rtl/ldiv_step.sv
module ldiv_step #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] quo_in,
    input  logic [W-1:0] dvsr,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out
);
    logic [W:0]   shifted;
    logic [W+1:0] diff;
    logic         fits;

    always_comb begin
        shifted = {rem_in, quo_in[W-1]};
        diff    = {1'b0, shifted} - {2'b00, dvsr};
        fits    = !diff[W+1];
        rem_out = fits ? diff[W-1:0] : shifted[W-1:0];
        quo_out = {quo_in[W-2:0], fits};
    end
endmodule

// File: rtl/ldiv_wb.sv
module ldiv_wb
    import ldiv_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fin,
    input  ldiv_outcome_e outcome,
    input  logic [W-1:0]  quo,
    input  logic [W-1:0]  rem,
    input  logic [IW-1:0] qidx,
    input  logic [IW-1:0] ridx,
    output logic          div_zero,
    output logic          q_we,
    output logic [IW-1:0] q_widx,
    output logic [W-1:0]  q_wdata,
    output logic          r_we,
    output logic [IW-1:0] r_widx,
    output logic [W-1:0]  r_wdata,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c
);
    logic ok;

    always_comb begin
        ok       = fin && (outcome == OUT_OK);
        div_zero = fin && (outcome == OUT_DZ);
        flag_v   = fin && (outcome == OUT_OVF);
        flag_c   = 1'b0;
        flag_n   = ok && quo[W-1];
        flag_z   = ok && (quo == '0);
        q_we     = ok;
        r_we     = ok && (ridx != qidx);
        q_widx   = qidx;
        r_widx   = ridx;
        q_wdata  = quo;
        r_wdata  = rem;
    end

    AST_DZ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> (!q_we && !r_we && !flag_v && !flag_n && !flag_z)); // R5
    AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk) disable iff (rst)
        flag_v |-> (!q_we && !r_we && !flag_n && !flag_z && !div_zero)); // R6
    AST_REM_PAIRED: assert property (@(posedge clk) disable iff (rst)
        r_we |-> (q_we && r_widx != q_widx)); // R3
    AST_FLAGS_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        (flag_n || flag_z || flag_v || div_zero) |-> fin); // R4
endmodule

// File: rtl/udiv_long.sv
module udiv_long
    import ldiv_pkg::*;
#(
    parameter int unsigned DATA_W = LDIV_DATA_W,
    parameter int unsigned IDX_W  = LDIV_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              size64,
    input  logic [DATA_W-1:0] divisor,
    input  logic [DATA_W-1:0] qreg_val,
    input  logic [DATA_W-1:0] rreg_val,
    input  logic [IDX_W-1:0]  qreg_idx,
    input  logic [IDX_W-1:0]  rreg_idx,
    output logic              busy,
    output logic              done,
    output logic              div_zero,
    output logic              q_we,
    output logic [IDX_W-1:0]  q_widx,
    output logic [DATA_W-1:0] q_wdata,
    output logic              r_we,
    output logic [IDX_W-1:0]  r_widx,
    output logic [DATA_W-1:0] r_wdata,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);
    ldiv_state_e   state;
    ldiv_outcome_e outcome_q;
    logic load, step_en, setup_fail;
    logic [DATA_W-1:0] dvsr_q, rem_q, quo_q, rem_nx, quo_nx;
    logic [IDX_W-1:0]  qidx_q, ridx_q;

    // rem_q holds the upper dividend half until the loop begins
    assign setup_fail = (dvsr_q == '0) || (rem_q >= dvsr_q);

    ldiv_ctrl #(.ITERS(DATA_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .setup_fail(setup_fail),
        .state(state), .load(load), .step_en(step_en), .busy(busy), .done(done)
    );

    ldiv_step #(.W(DATA_W)) u_step (
        .rem_in(rem_q), .quo_in(quo_q), .dvsr(dvsr_q),
        .rem_out(rem_nx), .quo_out(quo_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dvsr_q    <= '0;
            rem_q     <= '0;
            quo_q     <= '0;
            qidx_q    <= '0;
            ridx_q    <= '0;
            outcome_q <= OUT_OK;
        end else if (load) begin
            dvsr_q <= divisor;
            quo_q  <= qreg_val;
            rem_q  <= size64 ? rreg_val : '0;
            qidx_q <= qreg_idx;
            ridx_q <= rreg_idx;
        end else if (state == ST_SETUP) begin
            outcome_q <= ldiv_classify(dvsr_q == '0, rem_q >= dvsr_q);
        end else if (step_en) begin
            rem_q <= rem_nx;
            quo_q <= quo_nx;
        end
    end

    ldiv_wb #(.W(DATA_W), .IW(IDX_W)) u_wb (
        .clk(clk), .rst(rst), .fin(done), .outcome(outcome_q),
        .quo(quo_q), .rem(rem_q), .qidx(qidx_q), .ridx(ridx_q),
        .div_zero(div_zero),
        .q_we(q_we), .q_widx(q_widx), .q_wdata(q_wdata),
        .r_we(r_we), .r_widx(r_widx), .r_wdata(r_wdata),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    AST_REM_BELOW_DVSR: assert property (@(posedge clk) disable iff (rst)
        step_en |-> (rem_q < dvsr_q)); // R2
    AST_WRITE_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
        (q_we || r_we) |-> done); // R3
endmodule

// File: tb/tb_udiv_long.sv
module tb_udiv_long;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, start, size64;
    logic [31:0] divisor, qreg_val, rreg_val;
    logic [2:0]  qreg_idx, rreg_idx;
    logic        busy, done, div_zero, q_we, r_we;
    logic [2:0]  q_widx, r_widx;
    logic [31:0] q_wdata, r_wdata;
    logic        flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    udiv_long dut (
        .clk(clk), .rst(rst), .start(start), .size64(size64), .divisor(divisor),
        .qreg_val(qreg_val), .rreg_val(rreg_val), .qreg_idx(qreg_idx), .rreg_idx(rreg_idx),
        .busy(busy), .done(done), .div_zero(div_zero),
        .q_we(q_we), .q_widx(q_widx), .q_wdata(q_wdata),
        .r_we(r_we), .r_widx(r_widx), .r_wdata(r_wdata),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Runs one division; poke injects a foreign start while busy (R8).
    task automatic do_op(input string req, input bit s64, input logic [31:0] d, qv, rv,
                         input logic [2:0] qi, ri, input bit poke);
        logic [63:0] dividend, qfull;
        bit exp_dz, exp_ov, exp_ok;
        logic [31:0] eq, er;
        int n = 0;
        bit seen = 0;
        dividend = s64 ? {rv, qv} : {32'h0, qv};
        exp_dz = (d == 0);
        qfull  = exp_dz ? 64'h0 : dividend / {32'h0, d};
        er     = exp_dz ? 32'h0 : 32'(dividend % {32'h0, d});
        exp_ov = !exp_dz && (qfull > 64'hFFFF_FFFF);
        exp_ok = !exp_dz && !exp_ov;
        eq     = qfull[31:0];
        @(negedge clk);
        start = 1; size64 = s64; divisor = d; qreg_val = qv; rreg_val = rv;
        qreg_idx = qi; rreg_idx = ri;
        while (!seen && n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 0;
            if (poke && n == 5) begin
                start = 1; size64 = 0; divisor = 32'd3; qreg_val = 32'd1000;
                qreg_idx = 3'd7; rreg_idx = 3'd6;
            end
            if (done) seen = 1;
        end
        start = 0;
        chk("R7", "done seen", seen, 1);
        chk("R7", "latency", n, exp_ok ? 34 : 2);
        chk("R5", "div_zero", div_zero, exp_dz);
        chk("R6", "flag_v", flag_v, exp_ov);
        chk("R4", "flag_c", flag_c, 0);
        chk("R4", "flag_z", flag_z, exp_ok && eq == 0);
        chk("R4", "flag_n", flag_n, exp_ok && eq[31]);
        chk(req, "q_we", q_we, exp_ok);
        chk("R3", "r_we", r_we, exp_ok && qi != ri);
        if (exp_ok) begin
            chk(req, "quotient", q_wdata, eq);
            chk(req, "q_widx", q_widx, qi);
            if (qi != ri) begin
                chk(req, "remainder", r_wdata, er);
                chk(req, "r_widx", r_widx, ri);
            end
        end
        @(negedge clk);
        chk("R7", "done one cycle", done, 0);
        if (poke) begin
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                chk("R8", "no second done", done, 0);
                chk("R8", "no busy after ignored start", busy, 0);
            end
        end
    endtask

    task automatic t_reset;
        chk("R9", "busy", busy, 0);
        chk("R9", "done", done, 0);
        chk("R9", "writes", {q_we, r_we}, 0);
        chk("R9", "flags", {div_zero, flag_n, flag_z, flag_v, flag_c}, 0);
    endtask

    task automatic t_narrow;
        do_op("R1", 0, 32'd100000, 32'd100, 32'hDEAD_BEEF, 3'd4, 3'd3, 0);
        do_op("R1", 0, 32'd100000, 32'd100, 32'h0000_0000, 3'd4, 3'd3, 0);
        do_op("R1", 0, 32'd7, 32'd1_000_003, 32'hFFFF_FFFF, 3'd1, 3'd2, 0);
        do_op("R1", 0, 32'd100, 32'd0, 32'd100, 3'd4, 3'd3, 0);
        do_op("R1", 0, 32'd1, 32'hFFFF_FFFF, 32'd5, 3'd0, 3'd1, 0);
    endtask

    task automatic t_wide;
        do_op("R2", 1, 32'd100000, 32'h1234_5678, 32'd99999, 3'd2, 3'd5, 0);
        do_op("R2", 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 3'd6, 3'd7, 0);
        do_op("R2", 1, 32'h8000_0001, 32'h0, 32'h4000_0000, 3'd0, 3'd1, 0);
    endtask

    task automatic t_same_idx;
        do_op("R3", 0, 32'd9, 32'd100, 32'd0, 3'd5, 3'd5, 0);
        do_op("R3", 1, 32'd10, 32'd77, 32'd3, 3'd2, 3'd2, 0);
    endtask

    task automatic t_div_zero;
        do_op("R5", 0, 32'd0, 32'd55, 32'd1, 3'd1, 3'd2, 0);
        do_op("R5", 1, 32'd0, 32'd55, 32'd1, 3'd1, 3'd2, 0);
    endtask

    task automatic t_overflow;
        do_op("R6", 1, 32'd1000, 32'd0, 32'd1000, 3'd1, 3'd2, 0);
        do_op("R6", 1, 32'd1000, 32'd5, 32'd2000, 3'd1, 3'd2, 0);
        do_op("R6", 1, 32'd1000, 32'hFFFF_FFFF, 32'd999, 3'd1, 3'd2, 0);
    endtask

    task automatic t_busy;
        do_op("R8", 0, 32'd13, 32'd1_000_000, 32'd0, 3'd3, 3'd4, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1; start = 0; size64 = 0; divisor = 0; qreg_val = 0; rreg_val = 0;
        qreg_idx = 0; rreg_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_narrow();
        t_wide();
        t_same_idx();
        t_div_zero();
        t_overflow();
        t_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule